// File: doc/BRIEF.md
# Sectioned Program Address Counter

This block holds a virtual address split into a section number in the upper bits and an in-section offset in the lower bits. It advances in one of two ways. In program mode the offset counts on its own and wraps at the end of the section, so the section number never changes. In data mode the whole address counts as one value, so a step past the last offset of a section lands at the start of the next section.

Each cycle the block may advance by zero, one or two. A step input adds one, and a skip input adds one more. A load input replaces the whole address with a target value, and this is the only way the program can change section. A single-section strap holds the section bits at zero whatever else happens, which reduces the register to an offset-only counter.

Top module: `sectioned_addr_ctr`

## Requirements
- R1: While rst_ni is low, addr_o is zero.
- R2: With mode_i = 0 (program), step_i = 1, skip_i = 0 and load_i = 0, the offset field (addr_o[OFF_W-1:0]) becomes the old offset plus one modulo 2^OFF_W on the next clock edge, and the section field (addr_o[SEC_W+OFF_W-1:OFF_W]) is unchanged.
- R3: With mode_i = 1 (data), step_i = 1, skip_i = 0 and load_i = 0, addr_o becomes the old full address plus one, so a carry out of the offset field raises the section field by one.
- R4: skip_i adds one to the advance: step and skip together advance by two, and skip alone advances by one, each wrapping by the same rule as the selected mode.
- R5: With load_i = 1, addr_o takes target_i on the next clock edge, whatever step_i, skip_i and mode_i are.
- R6: With single_sec_i = 1, the section field after the next clock edge is zero, whether the cycle loads a target with a non-zero section or carries out of the offset in data mode.
- R7: With step_i, skip_i and load_i all low, addr_o keeps its value.
- R8: In data mode the full address wraps from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Advance by one |
| skip_i | input | 1 | Advance by one extra |
| mode_i | input | 1 | 0: program counting, 1: data stepping |
| single_sec_i | input | 1 | Hold the section field at zero |
| load_i | input | 1 | Load target_i; overrides advancing |
| target_i | input | SEC_W+OFF_W | Jump target |
| addr_o | output | SEC_W+OFF_W | Current virtual address |

## Verification
The two functions that can fall in one cycle are the load and the advance: both step and skip are raised together with load_i for every start address, and the result must equal the target exactly and show no trace of the advance. A second overlap comes from the offset carry meeting the section rules in one cycle. The bench reaches it by loading every offset at the section end in both modes, with and without the strap, then checking whether the section field stays put, moves up by one, or reads zero.

// File: rtl/sac_pkg.sv
package sac_pkg;
  localparam int SAC_SEC_W = 5;
  localparam int SAC_OFF_W = 18;

  typedef enum logic {
    STEP_PROG = 1'b0,
    STEP_DATA = 1'b1
  } step_mode_e;
endpackage

// File: rtl/sac_amount.sv
module sac_amount (
  input  logic       step_i,
  input  logic       skip_i,
  output logic [1:0] amt_o
);
  assign amt_o = {1'b0, step_i} + {1'b0, skip_i};
endmodule

// File: rtl/sac_adder.sv
module sac_adder #(
  parameter int W = 18
) (
  input  logic [W-1:0] a_i,
  input  logic [1:0]   inc_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o
);
  logic [W:0] ext_sum;

  assign ext_sum = {1'b0, a_i} + (W+1)'(inc_i);
  assign sum_o   = ext_sum[W-1:0];
  assign carry_o = ext_sum[W];
endmodule

// File: rtl/sectioned_addr_ctr.sv
module sectioned_addr_ctr
  import sac_pkg::*;
#(
  parameter int SEC_W = SAC_SEC_W,
  parameter int OFF_W = SAC_OFF_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   step_i,
  input  logic                   skip_i,
  input  logic                   mode_i,
  input  logic                   single_sec_i,
  input  logic                   load_i,
  input  logic [SEC_W+OFF_W-1:0] target_i,
  output logic [SEC_W+OFF_W-1:0] addr_o
);
  localparam int ADDR_W = SEC_W + OFF_W;

  logic [OFF_W-1:0] off_q, off_d, off_sum;
  logic [SEC_W-1:0] sec_q, sec_d, sec_sum;
  logic [1:0]       amt, sec_inc;
  logic             off_carry, sec_carry_unused;
  step_mode_e       mode;

  assign mode = step_mode_e'(mode_i);

  sac_amount i_amount (
    .step_i (step_i),
    .skip_i (skip_i),
    .amt_o  (amt)
  );

  sac_adder #(.W(OFF_W)) i_off_add (
    .a_i     (off_q),
    .inc_i   (amt),
    .sum_o   (off_sum),
    .carry_o (off_carry)
  );

  // program counting never carries into the section
  assign sec_inc = (mode == STEP_DATA) ? {1'b0, off_carry} : 2'b00;

  sac_adder #(.W(SEC_W)) i_sec_add (
    .a_i     (sec_q),
    .inc_i   (sec_inc),
    .sum_o   (sec_sum),
    .carry_o (sec_carry_unused)
  );

  always_comb begin
    if (load_i) begin
      off_d = target_i[OFF_W-1:0];
      sec_d = target_i[ADDR_W-1:OFF_W];
    end else begin
      off_d = off_sum;
      sec_d = sec_sum;
    end
    if (single_sec_i) sec_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q <= '0;
      sec_q <= '0;
    end else begin
      off_q <= off_d;
      sec_q <= sec_d;
    end
  end

  assign addr_o = {sec_q, off_q};
endmodule

// File: rtl/sac_checker.sv
module sac_checker #(
  parameter int SEC_W = 5,
  parameter int OFF_W = 18
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   step_i,
  input logic                   skip_i,
  input logic                   mode_i,
  input logic                   single_sec_i,
  input logic                   load_i,
  input logic [SEC_W+OFF_W-1:0] target_i,
  input logic [SEC_W+OFF_W-1:0] addr_o
);
  localparam int ADDR_W = SEC_W + OFF_W;

  logic [OFF_W-1:0] off;
  logic [SEC_W-1:0] sec;
  assign off = addr_o[OFF_W-1:0];
  assign sec = addr_o[ADDR_W-1:OFF_W];

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !skip_i && !load_i) |=> $stable(addr_o));

  a_r5_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !single_sec_i) |=> (addr_o == $past(target_i)));

  a_r6_single_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    single_sec_i |=> (sec == '0));

  a_r2_sec_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !mode_i && !single_sec_i) |=> (sec == $past(sec)));

  a_r2_prog_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !skip_i && !load_i && !mode_i) |=> (off == OFF_W'($past(off) + 1)));

  a_r4_double: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && skip_i && !load_i && !mode_i) |=> (off == OFF_W'($past(off) + 2)));

  a_r3_data_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !skip_i && !load_i && mode_i && !single_sec_i)
      |=> (addr_o == ADDR_W'($past(addr_o) + 1)));
endmodule

bind sectioned_addr_ctr sac_checker #(.SEC_W(SEC_W), .OFF_W(OFF_W)) i_sac_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .step_i       (step_i),
  .skip_i       (skip_i),
  .mode_i       (mode_i),
  .single_sec_i (single_sec_i),
  .load_i       (load_i),
  .target_i     (target_i),
  .addr_o       (addr_o)
);

// File: tb/test_sectioned_addr_ctr.sv
module test_sectioned_addr_ctr;
  localparam int SW = 3;
  localparam int OW = 4;
  localparam int AW = SW + OW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          step = 1'b0, skip = 1'b0, mode = 1'b0, single = 1'b0, load = 1'b0;
  logic [AW-1:0] target = '0;
  logic [AW-1:0] addr;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sectioned_addr_ctr #(.SEC_W(SW), .OFF_W(OW)) i_sectioned_addr_ctr (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .step_i       (step),
    .skip_i       (skip),
    .mode_i       (mode),
    .single_sec_i (single),
    .load_i       (load),
    .target_i     (target),
    .addr_o       (addr)
  );

  task automatic check(input string req, input logic [AW-1:0] exp);
    total++;
    if (addr !== exp) begin
      bad++;
      $display("FAIL %s: addr=%0h expected=%0h", req, addr, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [AW-1:0] advance(input logic [AW-1:0] cur, input int amt,
                                            input bit dmode, input bit ss);
    logic [AW-1:0] r;
    if (dmode) r = AW'(int'(cur) + amt);
    else r = {cur[AW-1:OW], OW'(int'(cur[OW-1:0]) + amt)};
    if (ss) r[AW-1:OW] = '0;
    return r;
  endfunction

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick();
    check("R1", '0);
    rst_n = 1'b1;
    tick();
    check("R7", '0);  // idle after reset keeps zero

    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 2; s++) begin
        for (int a = 0; a < (1 << AW); a++) begin
          for (int c = 0; c < 4; c++) begin
            logic [AW-1:0] start, exp;
            string tag;
            // load with step and skip also raised per c: load must win
            mode = m[0]; single = s[0];
            step = c[0]; skip = c[1]; load = 1'b1;
            target = AW'(a);
            tick();
            start = AW'(a);
            if (s != 0) start[AW-1:OW] = '0;
            check(s != 0 ? "R6" : "R5", start);

            load = 1'b0;
            tick();
            exp = advance(start, c[0] + c[1], m[0], s[0]);
            if (c == 0) tag = "R7";
            else if (c[1]) tag = "R4";
            else if (s != 0) tag = "R6";
            else if (m != 0 && start == '1) tag = "R8";
            else if (m != 0) tag = "R3";
            else tag = "R2";
            check(tag, exp);
          end
        end
      end
    end

    // reset in mid-run returns to zero
    mode = 1'b1; single = 1'b0; step = 1'b0; skip = 1'b0;
    load = 1'b1; target = '1;
    tick();
    load = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R1", '0);
    tick();
    rst_n = 1'b1;

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule